// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves a virtual address into a physical page when the translation cache misses. It starts at a context table whose location comes from a context table pointer and a context number. From there it reads 32-bit descriptors one at a time over a simple read/write memory port. It descends through up to three table levels until it reaches a page table entry or a fault. It reports the page physical address, the page size, the final entry and a level-tagged fault code. When the entry's referenced or modified bit must change, it writes the entry back to memory before it reports completion.

Two other modes share the same request port. A probe request returns the descriptor found at a chosen level, or the first page table entry on the path. A probe never writes back. A bypass request skips the tables altogether: the virtual address passes through unchanged, except for instruction fetches in boot mode, which are redirected into the boot ROM window. Only one request is in flight at a time. The block raises `busy` while it works and pulses `done` when the result registers are valid.

Top module: `ptw_walker`

## Requirements
- R1: The first read of a table walk goes to (cfg_ctx_ptr << 4) + (cfg_ctx_num << 2), the context level (level 0).
- R2: A descriptor's type is its bits [1:0]: 0 = invalid, 1 = table pointer, 2 = page entry, 3 = reserved. After a table pointer read at level L, the next read goes to ((desc & ~3) << 4) plus VA[31:24]*4 for L=0, VA[23:18]*4 for L=1, or VA[17:12]*4 for L=2.
- R3: A page entry at level 1 maps 16 MB (rsp_size 2, offset VA[23:12]). At level 2 it maps 256 KB (rsp_size 1, offset VA[17:12]). At level 3 it maps 4 KB (rsp_size 0). rsp_pa is (entry[31:8] << 12) plus the offset shifted left by 12.
- R4: rsp_fault has the level in bits [9:8] and the fault type in bits [4:2], with all other bits zero. An invalid descriptor gives type 1. On any fault rsp_entry is 0. rsp_fault is 0 on success.
- R5: Fault type 4 is reported for a reserved descriptor, a memory read error (mem_err with mem_ack), a page entry found at level 0, or a table pointer found at level 3.
- R6: On a non-probe walk, if the entry's referenced bit (bit 5) is clear, or the request is a store and the modified bit (bit 6) is clear, the entry is written back to the same address with bit 5 set, and bit 6 also set for a store. rsp_entry returns the updated value.
- R7: When neither bit needs to change, or in probe mode, no memory write occurs and rsp_entry is the entry as read.
- R8: A bypass request makes no memory access and completes one cycle later with rsp_size 0 and rsp_fault 0. A fetch with cfg_boot set returns cfg_prom_base | VA[18:0] with rsp_rx_only high. Every other bypass returns the zero-extended VA with rsp_rx_only low.
- R9: In probe mode with req_probe_lvl P of 3, 2 or 1, a table pointer read at level 3-P ends the walk and is returned. Otherwise the first page entry on the path is returned. Every fault case returns 0.
- R10: busy is high from the cycle after acceptance until done, and done is a one-cycle pulse with busy low. Requests while busy are ignored. mem_rd_req and mem_wr_req are never both high, and each holds its address until mem_ack.
- R11: After reset, busy, done, mem_rd_req and mem_wr_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a request (taken when busy is low) |
| req_va | input | 32 | Virtual address |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_probe | input | 1 | Probe mode |
| req_probe_lvl | input | 2 | Probe target level (3 context, 2, 1, 0 = entry) |
| req_bypass | input | 1 | Translation bypassed |
| cfg_ctx_ptr | input | 32 | Context table pointer |
| cfg_ctx_num | input | CTX_W | Context number |
| cfg_boot | input | 1 | Boot mode |
| cfg_prom_base | input | PA_W | Boot ROM base address |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| rsp_pa | output | PA_W | Physical page address |
| rsp_size | output | 2 | Page size code |
| rsp_entry | output | 32 | Final descriptor or 0 |
| rsp_fault | output | 10 | Fault code |
| rsp_rx_only | output | 1 | Boot ROM mapping, read/execute only |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | PA_W | Memory address |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory transfer complete |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read error |

## Verification
A wrong level counter or a wrong index selection shows up at the very next memory read as a wrong mem_addr. Because the bench memory returns lazily generated descriptors, the effect then spreads to rsp_pa, rsp_size or a wrongly levelled fault code when done pulses. A decoding error in the write-back condition shows up as an extra or missing write, which the bench counts, or as wrong bits 5 and 6 in memory right after done. A stuck state shows up as a missing done within a few hundred cycles.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DESC_W   = 32;
  localparam int VA_W     = 32;
  localparam int VPN_W    = VA_W - 12;
  localparam int LVL_W    = 2;
  localparam int FAULT_W  = 10;
  localparam int REF_BIT  = 5;
  localparam int MOD_BIT  = 6;
  localparam logic [LVL_W-1:0] LAST_LVL = 2'd3;
  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_TRANS   = 3'd4;

  typedef enum logic [1:0] {
    ET_INVALID = 2'd0,
    ET_PTD     = 2'd1,
    ET_PTE     = 2'd2,
    ET_RSVD    = 2'd3
  } etype_e;

  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_LEAF    = 2'd1,
    ACT_FAULT   = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    SZ_4K   = 2'd0,
    SZ_256K = 2'd1,
    SZ_16M  = 2'd2
  } psize_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2
  } wstate_e;

  function automatic logic [FAULT_W-1:0] fault_code(input logic [LVL_W-1:0] lvl,
                                                    input logic [2:0] ft);
    return {lvl, 3'b000, ft, 2'b00};
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic [31:0]       ctx_ptr,
  input  logic [CTX_W-1:0]  ctx_num,
  input  logic [31:2]       desc_hi,
  input  logic [VPN_W-1:0]  vpn,
  input  logic [LVL_W-1:0]  lvl,
  output logic [PA_W-1:0]   root_addr,
  output logic [PA_W-1:0]   child_addr
);
  localparam int IDX_W = 10;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  base;

  assign root_addr = PA_W'({ctx_ptr, 4'b0000}) + PA_W'({ctx_num, 2'b00});

  always_comb begin
    unique case (lvl)
      2'd0:    idx = {vpn[19:12], 2'b00};
      2'd1:    idx = {2'b00, vpn[11:6], 2'b00};
      default: idx = {2'b00, vpn[5:0], 2'b00};
    endcase
  end

  assign base       = PA_W'({desc_hi, 6'b000000});
  assign child_addr = base + PA_W'(idx);
endmodule

// File: rtl/ptw_classify.sv
module ptw_classify
  import ptw_pkg::*;
(
  input  logic [1:0]       etype,
  input  logic             rd_err,
  input  logic [LVL_W-1:0] lvl,
  input  logic             probe,
  input  logic [1:0]       probe_lvl,
  output act_e             act,
  output logic             probe_hit,
  output logic [2:0]       ftype
);
  always_comb begin
    act       = ACT_FAULT;
    probe_hit = 1'b0;
    ftype     = FT_TRANS;
    if (!rd_err) begin
      unique case (etype_e'(etype))
        ET_INVALID: ftype = FT_INVALID;
        ET_RSVD:    ftype = FT_TRANS;
        ET_PTE: begin
          if (lvl != 2'd0) act = ACT_LEAF;
        end
        ET_PTD: begin
          if (lvl != LAST_LVL) begin
            if (probe && (probe_lvl == 2'(LAST_LVL - lvl))) begin
              act       = ACT_LEAF;
              probe_hit = 1'b1;
            end else begin
              act = ACT_DESCEND;
            end
          end
        end
        default: ftype = FT_TRANS;
      endcase
    end
  end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
  import ptw_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [DESC_W-1:0] desc,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [VPN_W-1:0]  vpn,
  input  logic              store,
  output logic [PA_W-1:0]   pa,
  output psize_e            size,
  output logic              wb_need,
  output logic [DESC_W-1:0] wb_data
);
  logic [23:0] off;

  always_comb begin
    unique case (lvl)
      2'd1: begin
        off  = {vpn[11:0], 12'h000};
        size = SZ_16M;
      end
      2'd2: begin
        off  = {6'd0, vpn[5:0], 12'h000};
        size = SZ_256K;
      end
      default: begin
        off  = 24'd0;
        size = SZ_4K;
      end
    endcase
  end

  assign pa      = PA_W'({desc[31:8], 12'h000}) + PA_W'(off);
  assign wb_need = !desc[REF_BIT] || (store && !desc[MOD_BIT]);

  always_comb begin
    wb_data          = desc;
    wb_data[REF_BIT] = 1'b1;
    if (store) wb_data[MOD_BIT] = 1'b1;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_va,
  input  logic              req_store,
  input  logic              req_fetch,
  input  logic              req_probe,
  input  logic [1:0]        req_probe_lvl,
  input  logic              req_bypass,
  input  logic [31:0]       cfg_ctx_ptr,
  input  logic [CTX_W-1:0]  cfg_ctx_num,
  input  logic              cfg_boot,
  input  logic [PA_W-1:0]   cfg_prom_base,
  output logic              busy,
  output logic              done,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_size,
  output logic [31:0]       rsp_entry,
  output logic [9:0]        rsp_fault,
  output logic              rsp_rx_only,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [PA_W-1:0]   mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err
);
  localparam int BOOT_W = 19;

  wstate_e              state_q, state_n;
  logic [LVL_W-1:0]     lvl_q, lvl_n;
  logic [PA_W-1:0]      addr_q, addr_n;
  logic [DESC_W-1:0]    wdata_q, wdata_n;
  logic                 done_q, done_n;
  logic [VPN_W-1:0]     vpn_q;
  logic                 store_q, probe_q;
  logic [1:0]           plvl_q;
  logic                 cap_en;

  logic                 rsp_en;
  logic [PA_W-1:0]      pa_q, pa_n;
  psize_e               size_q, size_n;
  logic [DESC_W-1:0]    entry_q, entry_n;
  logic [FAULT_W-1:0]   fault_q, fault_n;
  logic                 rx_q, rx_n;

  logic [PA_W-1:0]      root_addr, child_addr;
  act_e                 act;
  logic                 probe_hit;
  logic [2:0]           ftype;
  logic [PA_W-1:0]      leaf_pa;
  psize_e               leaf_size;
  logic                 wb_need;
  logic [DESC_W-1:0]    wb_data;
  logic                 boot_map;

  ptw_addr_gen #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
    .ctx_ptr    (cfg_ctx_ptr),
    .ctx_num    (cfg_ctx_num),
    .desc_hi    (mem_rdata[31:2]),
    .vpn        (vpn_q),
    .lvl        (lvl_q),
    .root_addr  (root_addr),
    .child_addr (child_addr)
  );

  ptw_classify u_cls (
    .etype     (mem_rdata[1:0]),
    .rd_err    (mem_err),
    .lvl       (lvl_q),
    .probe     (probe_q),
    .probe_lvl (plvl_q),
    .act       (act),
    .probe_hit (probe_hit),
    .ftype     (ftype)
  );

  ptw_leaf #(.PA_W(PA_W)) u_leaf (
    .desc    (mem_rdata),
    .lvl     (lvl_q),
    .vpn     (vpn_q),
    .store   (store_q),
    .pa      (leaf_pa),
    .size    (leaf_size),
    .wb_need (wb_need),
    .wb_data (wb_data)
  );

  assign boot_map = cfg_boot && req_fetch;

  always_comb begin
    state_n = state_q;
    lvl_n   = lvl_q;
    addr_n  = addr_q;
    wdata_n = wdata_q;
    done_n  = 1'b0;
    cap_en  = 1'b0;
    rsp_en  = 1'b0;
    pa_n    = pa_q;
    size_n  = size_q;
    entry_n = entry_q;
    fault_n = fault_q;
    rx_n    = rx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          if (req_bypass) begin
            rsp_en  = 1'b1;
            done_n  = 1'b1;
            pa_n    = boot_map ? (cfg_prom_base | PA_W'(req_va[BOOT_W-1:0]))
                               : PA_W'(req_va);
            size_n  = SZ_4K;
            entry_n = '0;
            fault_n = '0;
            rx_n    = boot_map;
          end else begin
            state_n = ST_FETCH;
            lvl_n   = '0;
            addr_n  = root_addr;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          unique case (act)
            ACT_DESCEND: begin
              lvl_n  = 2'(lvl_q + 2'd1);
              addr_n = child_addr;
            end
            ACT_LEAF: begin
              rsp_en  = 1'b1;
              pa_n    = leaf_pa;
              size_n  = leaf_size;
              fault_n = '0;
              rx_n    = 1'b0;
              if (wb_need && !probe_q && !probe_hit) begin
                state_n = ST_STORE;
                wdata_n = wb_data;
                entry_n = wb_data;
              end else begin
                state_n = ST_IDLE;
                entry_n = mem_rdata;
                done_n  = 1'b1;
              end
            end
            default: begin
              rsp_en  = 1'b1;
              state_n = ST_IDLE;
              done_n  = 1'b1;
              pa_n    = '0;
              size_n  = SZ_4K;
              entry_n = '0;
              fault_n = fault_code(lvl_q, ftype);
              rx_n    = 1'b0;
            end
          endcase
        end
      end
      ST_STORE: begin
        if (mem_ack) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      lvl_q   <= lvl_n;
      addr_q  <= addr_n;
      wdata_q <= wdata_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q   <= '0;
      store_q <= 1'b0;
      probe_q <= 1'b0;
      plvl_q  <= '0;
    end else if (cap_en) begin
      vpn_q   <= req_va[VA_W-1:12];
      store_q <= req_store;
      probe_q <= req_probe;
      plvl_q  <= req_probe_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      size_q  <= SZ_4K;
      entry_q <= '0;
      fault_q <= '0;
      rx_q    <= 1'b0;
    end else if (rsp_en) begin
      pa_q    <= pa_n;
      size_q  <= size_n;
      entry_q <= entry_n;
      fault_q <= fault_n;
      rx_q    <= rx_n;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign rsp_pa      = pa_q;
  assign rsp_size    = size_q;
  assign rsp_entry   = entry_q;
  assign rsp_fault   = fault_q;
  assign rsp_rx_only = rx_q;
  assign mem_rd_req  = (state_q == ST_FETCH);
  assign mem_wr_req  = (state_q == ST_STORE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_bypass,
  input logic [31:0]      cfg_ctx_ptr,
  input logic [CTX_W-1:0] cfg_ctx_num,
  input logic             busy,
  input logic             done,
  input logic [9:0]       rsp_fault,
  input logic [31:0]      rsp_entry,
  input logic             mem_rd_req,
  input logic             mem_wr_req,
  input logic [PA_W-1:0]  mem_addr,
  input logic [31:0]      mem_wdata,
  input logic             mem_ack
);
  // R10
  mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_ack) |=> (mem_wr_req && $stable(mem_addr)));

  // R1
  root_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_bypass) |=>
      (mem_rd_req && mem_addr == (PA_W'({$past(cfg_ctx_ptr), 4'b0000}) +
                                  PA_W'({$past(cfg_ctx_num), 2'b00}))));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_bypass) |=>
      (done && !busy && !mem_rd_req && !mem_wr_req));

  // R4
  fault_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_fault != 10'd0) |->
      (rsp_fault[1:0] == 2'b00 && rsp_fault[7:5] == 3'b000 &&
       (rsp_fault[4:2] == 3'd1 || rsp_fault[4:2] == 3'd4) && rsp_entry == 32'd0));

  // R6
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> mem_wdata[5]);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W), .CTX_W(CTX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_bypass  (req_bypass),
  .cfg_ctx_ptr (cfg_ctx_ptr),
  .cfg_ctx_num (cfg_ctx_num),
  .busy        (busy),
  .done        (done),
  .rsp_fault   (rsp_fault),
  .rsp_entry   (rsp_entry),
  .mem_rd_req  (mem_rd_req),
  .mem_wr_req  (mem_wr_req),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_ack     (mem_ack)
);

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W  = 36;
  localparam int CTX_W = 8;
  localparam logic [31:0]     CTX_PTR = 32'h0000_1000;
  localparam logic [PA_W-1:0] PROM    = 36'h8_0000_0000;

  logic clk, rst_n;
  logic req_valid, req_store, req_fetch, req_probe, req_bypass;
  logic [31:0] req_va;
  logic [1:0]  req_probe_lvl;
  logic [31:0] cfg_ctx_ptr;
  logic [CTX_W-1:0] cfg_ctx_num;
  logic cfg_boot;
  logic [PA_W-1:0] cfg_prom_base;
  logic busy, done, rsp_rx_only;
  logic [PA_W-1:0] rsp_pa;
  logic [1:0] rsp_size;
  logic [31:0] rsp_entry;
  logic [9:0] rsp_fault;
  logic mem_rd_req, mem_wr_req, mem_ack, mem_err;
  logic [PA_W-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_err = 0;
  int wr_count = 0;
  bit [31:0] mem [bit [PA_W-1:0]];
  bit        errs [bit [PA_W-1:0]];

  bit [PA_W-1:0] e_pa, e_wb_addr;
  bit [1:0]      e_size;
  bit [31:0]     e_entry, e_wb_data;
  bit [9:0]      e_fault;
  bit            e_rx, e_wb, e_has_pa;

  ptw_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_store(req_store), .req_fetch(req_fetch), .req_probe(req_probe),
    .req_probe_lvl(req_probe_lvl), .req_bypass(req_bypass),
    .cfg_ctx_ptr(cfg_ctx_ptr), .cfg_ctx_num(cfg_ctx_num), .cfg_boot(cfg_boot),
    .cfg_prom_base(cfg_prom_base), .busy(busy), .done(done), .rsp_pa(rsp_pa),
    .rsp_size(rsp_size), .rsp_entry(rsp_entry), .rsp_fault(rsp_fault),
    .rsp_rx_only(rsp_rx_only), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: registered one-cycle ack after a random delay
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_rdata <= '0; mem_err <= 1'b0;
    end else if (!mem_ack && (mem_rd_req || mem_wr_req) && $urandom_range(0, 3) != 0) begin
      mem_ack <= 1'b1;
      if (mem_wr_req) begin
        mem[mem_addr] = mem_wdata;
        wr_count++;
        mem_err <= 1'b0;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'd0;
        mem_err   <= errs.exists(mem_addr);
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit [9:0] fc(input int lvl, input bit [2:0] ft);
    return {lvl[1:0], 3'd0, ft, 2'd0};
  endfunction

  function automatic bit [31:0] mk_ptd(input bit [PA_W-1:0] base);
    return {base[35:6], 2'b01};
  endfunction

  function automatic bit [31:0] mk_pte(input bit [23:0] ppn, input bit m, input bit r);
    return {ppn, 1'b0, m, r, 3'b011, 2'b10};
  endfunction

  function automatic bit [PA_W-1:0] idx_addr(input bit [PA_W-1:0] base, input int lvl,
                                             input bit [31:0] va);
    case (lvl)
      0: return base + {26'd0, va[31:24], 2'd0};
      1: return base + {28'd0, va[23:18], 2'd0};
      default: return base + {28'd0, va[17:12], 2'd0};
    endcase
  endfunction

  task automatic ensure(input bit [PA_W-1:0] a);
    int r;
    if (!mem.exists(a)) begin
      r = $urandom_range(0, 99);
      if (r < 6)       mem[a] = $urandom & 32'hFFFF_FFFC;
      else if (r < 10) mem[a] = $urandom | 32'h3;
      else if (r < 62) mem[a] = mk_ptd({12'd0, 18'($urandom), 6'd0});
      else             mem[a] = {$urandom, 2'b10} >> 0 & 32'hFFFF_FFFE | 32'h2;
      if ($urandom_range(0, 99) < 3) errs[a] = 1'b1;
    end
  endtask

  task automatic ref_walk(input bit [31:0] va, input bit [7:0] ctx, input bit store,
                          input bit fetch, input bit probe, input bit [1:0] plvl,
                          input bit bypass, input bit boot);
    bit [PA_W-1:0] a;
    bit [31:0] d;
    bit [23:0] off;
    int lvl;
    bit fin;
    e_pa = '0; e_size = 0; e_entry = 0; e_fault = 0; e_rx = 0; e_wb = 0;
    e_wb_addr = '0; e_wb_data = 0; e_has_pa = 0;
    if (bypass) begin
      e_rx = boot && fetch;
      e_pa = e_rx ? (PROM | {17'd0, va[18:0]}) : {4'd0, va};
      e_has_pa = 1;
      return;
    end
    a = {CTX_PTR, 4'd0} + {26'd0, ctx, 2'd0};
    lvl = 0; fin = 0;
    while (!fin) begin
      ensure(a);
      d = mem[a];
      fin = 1;
      if (errs.exists(a)) e_fault = fc(lvl, 3'd4);
      else if (d[1:0] == 2'd0) e_fault = fc(lvl, 3'd1);
      else if (d[1:0] == 2'd3) e_fault = fc(lvl, 3'd4);
      else if (d[1:0] == 2'd2) begin
        if (lvl == 0) e_fault = fc(0, 3'd4);
        else begin
          off = (lvl == 1) ? {va[23:12], 12'd0} : (lvl == 2) ? {6'd0, va[17:12], 12'd0} : 24'd0;
          e_size = (lvl == 1) ? 2'd2 : (lvl == 2) ? 2'd1 : 2'd0;
          e_pa = {d[31:8], 12'd0} + {12'd0, off};
          e_has_pa = 1;
          e_entry = d;
          if (!probe && (!d[5] || (store && !d[6]))) begin
            e_wb = 1; e_wb_addr = a;
            e_wb_data = d | 32'h20 | (store ? 32'h40 : 32'h0);
            e_entry = e_wb_data;
          end
        end
      end else begin
        if (lvl == 3) e_fault = fc(3, 3'd4);
        else if (probe && plvl == 2'(3 - lvl)) e_entry = d;
        else begin
          a = idx_addr({d[31:2], 6'd0}, lvl, va);
          lvl++;
          fin = 0;
        end
      end
    end
  endtask

  task automatic run(input bit [31:0] va, input bit [7:0] ctx, input bit store,
                     input bit fetch, input bit probe, input bit [1:0] plvl,
                     input bit bypass, input bit boot, input bit poke, input string tag);
    int w0, t;
    ref_walk(va, ctx, store, fetch, probe, plvl, bypass, boot);
    w0 = wr_count;
    @(negedge clk);
    cfg_ctx_num = ctx; cfg_boot = boot;
    req_valid = 1; req_va = va; req_store = store; req_fetch = fetch;
    req_probe = probe; req_probe_lvl = plvl; req_bypass = bypass;
    @(negedge clk);
    req_valid = 0;
    if (!bypass) begin
      chk(busy === 1'b1, "R10", {tag, " busy after accept"}, 64'(busy), 1);
      if (poke) begin
        req_valid = 1; req_bypass = 1; req_va = ~va;
      end
    end
    t = 0;
    while (!done && t < 400) begin
      @(negedge clk);
      req_valid = 0;
      t++;
    end
    chk(done === 1'b1, "R10", {tag, " done seen"}, 64'(done), 1);
    chk(rsp_fault === e_fault, e_fault[4:2] == 3'd1 ? "R4" : "R5", {tag, " fault"},
        64'(rsp_fault), 64'(e_fault));
    chk(rsp_entry === e_entry, probe ? "R9" : "R6", {tag, " entry"},
        64'(rsp_entry), 64'(e_entry));
    if (e_has_pa && e_fault == 0) begin
      chk(rsp_pa === e_pa, bypass ? "R8" : "R3", {tag, " pa"}, 64'(rsp_pa), 64'(e_pa));
      chk(rsp_size === e_size, bypass ? "R8" : "R3", {tag, " size"},
          64'(rsp_size), 64'(e_size));
    end
    chk(rsp_rx_only === e_rx, "R8", {tag, " rx_only"}, 64'(rsp_rx_only), 64'(e_rx));
    chk(wr_count - w0 == (e_wb ? 1 : 0), e_wb ? "R6" : "R7", {tag, " write count"},
        64'(wr_count - w0), 64'(e_wb));
    if (e_wb)
      chk(mem[e_wb_addr] === e_wb_data, "R6", {tag, " written entry"},
          64'(mem[e_wb_addr]), 64'(e_wb_data));
    @(negedge clk);
    chk(done === 1'b0, "R10", {tag, " done single pulse"}, 64'(done), 0);
  endtask

  function automatic bit [PA_W-1:0] ctxa(input int c);
    return {CTX_PTR, 4'd0} + c * 4;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    bit [PA_W-1:0] t1, t2, t3;
    bit [31:0] va;
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_va = 0; req_store = 0; req_fetch = 0;
    req_probe = 0; req_probe_lvl = 0; req_bypass = 0;
    cfg_ctx_ptr = CTX_PTR; cfg_ctx_num = 0; cfg_boot = 0; cfg_prom_base = PROM;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 0 && done === 0, "R11", "busy/done in reset", {62'd0, busy, done}, 0);
    chk(mem_rd_req === 0 && mem_wr_req === 0, "R11", "mem requests in reset",
        {62'd0, mem_rd_req, mem_wr_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    va = 32'h1234_5678;
    // R4: invalid context entry
    mem[ctxa(1)] = 32'h0;
    run(va, 1, 0, 0, 0, 0, 0, 0, 0, "R4 ctx invalid");
    // R5: page entry at context level
    mem[ctxa(2)] = mk_pte(24'h1, 1, 1);
    run(va, 2, 0, 0, 0, 0, 0, 0, 0, "R5 ctx pte");
    // R3/R6: 16 MB page, store with R clear
    t1 = 36'h1_0000_1000;
    mem[ctxa(3)] = mk_ptd(t1);
    mem[idx_addr(t1, 0, va)] = mk_pte(24'hABC000, 0, 0);
    run(va, 3, 1, 0, 0, 0, 0, 0, 0, "R3 16M store wb");
    // R2/R7: full walk to 4 KB page, bits already set
    t1 = 36'h1_0000_2000; t2 = 36'h1_0000_3000; t3 = 36'h1_0000_4000;
    mem[ctxa(4)] = mk_ptd(t1);
    mem[idx_addr(t1, 0, va)] = mk_ptd(t2);
    mem[idx_addr(t2, 1, va)] = mk_ptd(t3);
    mem[idx_addr(t3, 2, va)] = mk_pte(24'h55AA11, 1, 1);
    run(va, 4, 1, 0, 0, 0, 0, 0, 0, "R2 R7 4K no wb");
    // R10: request while busy ignored
    run(va, 4, 0, 0, 0, 0, 0, 0, 1, "R10 poke busy");
    // R9: probes at each level
    run(va, 4, 0, 0, 1, 3, 0, 0, 0, "R9 probe ctx");
    run(va, 4, 0, 0, 1, 2, 0, 0, 0, "R9 probe l1");
    run(va, 4, 0, 0, 1, 1, 0, 0, 0, "R9 probe l2");
    run(va, 4, 1, 0, 1, 0, 0, 0, 0, "R9 probe pte");
    run(va, 1, 0, 0, 1, 3, 0, 0, 0, "R9 probe invalid");
    // R5: memory error at level 2
    t1 = 36'h1_0000_5000; t2 = 36'h1_0000_6000;
    mem[ctxa(5)] = mk_ptd(t1);
    mem[idx_addr(t1, 0, va)] = mk_ptd(t2);
    mem[idx_addr(t2, 1, va)] = 32'h0;
    errs[idx_addr(t2, 1, va)] = 1;
    run(va, 5, 0, 0, 0, 0, 0, 0, 0, "R5 mem err l2");
    // R5: table pointer at level 3
    t1 = 36'h1_0000_7000; t2 = 36'h1_0000_8000; t3 = 36'h1_0000_9000;
    mem[ctxa(6)] = mk_ptd(t1);
    mem[idx_addr(t1, 0, va)] = mk_ptd(t2);
    mem[idx_addr(t2, 1, va)] = mk_ptd(t3);
    mem[idx_addr(t3, 2, va)] = mk_ptd(36'h1_0000_A000);
    run(va, 6, 0, 0, 0, 0, 0, 0, 0, "R5 ptd at l3");
    // R5: reserved at level 1
    t1 = 36'h1_0000_B000;
    mem[ctxa(7)] = mk_ptd(t1);
    mem[idx_addr(t1, 0, va)] = 32'h0000_0013;
    run(va, 7, 0, 0, 0, 0, 0, 0, 0, "R5 rsvd l1");
    // R3/R6: 256 KB page, store with R set M clear
    t1 = 36'h1_0000_C000; t2 = 36'h1_0000_D000;
    mem[ctxa(8)] = mk_ptd(t1);
    mem[idx_addr(t1, 0, va)] = mk_ptd(t2);
    mem[idx_addr(t2, 1, va)] = mk_pte(24'h7E0040, 0, 1);
    run(va, 8, 1, 0, 0, 0, 0, 0, 0, "R3 256K store M");
    // R8: bypass variants
    run(32'hDEAD_BEEF, 0, 0, 1, 0, 0, 1, 1, 0, "R8 boot fetch");
    run(32'hDEAD_BEEF, 0, 0, 0, 0, 0, 1, 1, 0, "R8 boot load");
    run(32'hCAFE_F00D, 0, 1, 1, 0, 0, 1, 0, 0, "R8 bypass fetch");

    // random walks (R1 R2 R3 R4 R5 R6 R7 R9)
    for (int i = 0; i < 400; i++) begin
      bit byp;
      byp = ($urandom_range(0, 99) < 5);
      run($urandom, 8'($urandom_range(16, 255)), 1'($urandom), 1'($urandom),
          ($urandom_range(0, 99) < 20), 2'($urandom), byp, 1'($urandom), 0, "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule